// File: doc/BRIEF.md
# Two-ring slot handshake controller

This block sequences the two handoffs of a streaming compute pipeline. A loader fills slots of a circular staging ring that a compute engine empties, and the compute engine in turn fills slots of a second ring of accumulators that a writeback stage drains in sub-tiles. The block keeps a fill parity and a drain parity for every slot. Each of the four agents keeps its own slot index and lap phase. It holds no data and generates no addresses. It only decides when each agent may take its current slot, and it records when the agent gives that slot back.

Every agent uses the same protocol. It raises an acquire request and receives a grant in the same cycle when its current slot is ready for it. It then holds the slot until it pulses its release, and that release advances its index. The writeback agent does not release with a pulse. It reports each drained sub-tile instead, and the block frees the accumulator after the last sub-tile. When the accumulator ring has a single slot and early freeing is enabled, the block frees that slot after a chosen sub-tile, so the compute engine can start the next tile while the rest is still being drained. Sideband counts report how many slots of each ring are full.

Top module: `pipe_sync_ctrl`

## Requirements
- R1: After reset every slot of both rings is empty, both full counts read 0, all slot indices read 0, and the next-sub-tile index reads 0.
- R2: A loader acquire is granted in the same cycle when the loader holds no slot and its current slot is empty. A loader release marks that slot full and advances the loader index by one, modulo LOAD_SLOTS.
- R3: While all LOAD_SLOTS staging slots are full, a loader acquire is not granted.
- R4: A compute acquire on the staging ring is granted only when its current slot is full. The compute release marks that slot empty, and an acquire against an all-empty ring is refused.
- R5: Slots are handed to the compute engine in the order the loader filled them, including across the wrap from slot LOAD_SLOTS-1 to slot 0. The lap phase of each agent toggles at every wrap.
- R6: A release from an agent that holds no slot is ignored, and leaves the full counts and the indices unchanged. An acquire from an agent that already holds a slot is not granted.
- R7: When a release empties a slot in the same cycle that the opposite agent requests that slot, the request is refused in that cycle and granted in the following cycle.
- R8: A compute acquire on the accumulator ring is granted only when its current accumulator slot is empty, and its release marks the slot full. A writeback acquire is granted only when its current accumulator slot is full.
- R9: While writeback holds a slot, each sub-tile pulse advances the next-sub-tile index. After SUBTILES pulses that index returns to 0 and writeback may acquire again. Sub-tile pulses while writeback holds no slot are ignored.
- R10: With ACC_SLOTS = 1 and EARLY_EN set, the accumulator is marked empty once sub-tile EARLY_AT has been drained. The compute engine may then acquire it, while writeback stays busy until its last sub-tile and is not granted a new acquire before that.
- R11: With ACC_SLOTS > 1, early freeing is not applied and a slot empties only after its last sub-tile. The compute engine rotates through the accumulator slots, so it can fill the next one while writeback drains another.
- R12: ld_full_cnt and acc_full_cnt equal the number of full slots in each ring, one cycle after the release that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_acq_req | input | 1 | Loader asks for its current staging slot |
| ld_acq_gnt | output | 1 | Loader may use the slot |
| ld_rel | input | 1 | Loader marks its held slot full |
| ld_slot | output | LIW | Loader's current staging slot |
| mc_acq_req | input | 1 | Compute asks for its current staging slot |
| mc_acq_gnt | output | 1 | Compute may read the slot |
| mc_rel | input | 1 | Compute marks its held staging slot empty |
| mc_slot | output | LIW | Compute's current staging slot |
| ma_acq_req | input | 1 | Compute asks for its current accumulator slot |
| ma_acq_gnt | output | 1 | Compute may accumulate into the slot |
| ma_rel | input | 1 | Compute marks its held accumulator full |
| ma_slot | output | AIW | Compute's current accumulator slot |
| wb_acq_req | input | 1 | Writeback asks for its current accumulator slot |
| wb_acq_gnt | output | 1 | Writeback may drain the slot |
| wb_sub_done | input | 1 | Writeback finished one sub-tile |
| wb_slot | output | AIW | Writeback's current accumulator slot |
| wb_sub | output | SW | Index of the next sub-tile to drain |
| ld_full_cnt | output | LCW | Number of full staging slots |
| acc_full_cnt | output | ACW | Number of full accumulator slots |

## Verification
The bench fills the whole staging ring and then requests one more slot. A controller that ignored the parity of a wrapped slot would grant a slot that still holds data. The bench then releases and requests the same slot in one cycle, which catches a controller that forwards the release into the grant or that loses the request entirely. Draining across the wrap with a scoreboard of fill order exposes a lap phase that does not toggle, because that fault stalls or reorders the compute grants. On the single accumulator, the bench checks the cycle in which the slot frees and that writeback stays locked out until its last sub-tile. A second instance with two accumulators confirms that early freeing stays off there, since a wrong gate would let compute overwrite a slot that is still being drained.

// File: rtl/pipe_sync_pkg.sv
package pipe_sync_pkg;

    // Which side of a ring an agent sits on.
    typedef enum logic {
        ROLE_FILL  = 1'b0,  // waits for an empty slot, releases it full
        ROLE_DRAIN = 1'b1   // waits for a full slot, releases it empty
    } side_role_e;

    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/slot_ring.sv
module slot_ring
    import pipe_sync_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int IW = idx_width(DEPTH),
    localparam int CW = cnt_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_i,
    input  logic [IW-1:0]    fill_idx_i,
    input  logic             drain_i,
    input  logic [IW-1:0]    drain_idx_i,
    output logic [DEPTH-1:0] fill_par_o,
    output logic [DEPTH-1:0] drain_par_o,
    output logic [CW-1:0]    full_cnt_o
);

    typedef struct packed {
        logic [DEPTH-1:0] fill_par;
        logic [DEPTH-1:0] drain_par;
    } ring_t;

    ring_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (fill_i && fill_idx_i == IW'(i)) begin
                s_d.fill_par[i] = ~s_q.fill_par[i];
            end
            if (drain_i && drain_idx_i == IW'(i)) begin
                s_d.drain_par[i] = ~s_q.drain_par[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        full_cnt_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            full_cnt_o = full_cnt_o + CW'(s_q.fill_par[i] ^ s_q.drain_par[i]);
        end
    end

    assign fill_par_o  = s_q.fill_par;
    assign drain_par_o = s_q.drain_par;

endmodule

// File: rtl/ring_side.sv
module ring_side
    import pipe_sync_pkg::*;
#(
    parameter int         DEPTH = 5,
    parameter side_role_e ROLE  = ROLE_FILL,
    localparam int IW = idx_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_req_i,
    input  logic [DEPTH-1:0] fill_par_i,
    input  logic [DEPTH-1:0] drain_par_i,
    input  logic             adv_i,     // move to the next slot
    input  logic             drop_i,    // stop holding
    output logic             acq_gnt_o,
    output logic             held_o,
    output logic [IW-1:0]    idx_o
);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          phase;
        logic          held;
    } side_t;

    side_t s_d, s_q;
    logic  cur_fill, cur_drain, ready;

    always_comb begin
        cur_fill  = 1'b0;
        cur_drain = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.idx == IW'(i)) begin
                cur_fill  = fill_par_i[i];
                cur_drain = drain_par_i[i];
            end
        end
    end

    generate
        if (ROLE == ROLE_FILL) begin : g_fill
            // previous lap of this slot has been drained
            assign ready = (cur_drain == s_q.phase);
        end else begin : g_drain
            // this lap of this slot has been filled
            assign ready = (cur_fill != s_q.phase);
        end
    endgenerate

    assign acq_gnt_o = acq_req_i && !s_q.held && ready;

    always_comb begin
        s_d = s_q;
        if (acq_gnt_o) begin
            s_d.held = 1'b1;
        end
        if (drop_i) begin
            s_d.held = 1'b0;
        end
        if (adv_i) begin
            if (s_q.idx == IW'(DEPTH - 1)) begin
                s_d.idx   = '0;
                s_d.phase = ~s_q.phase;
            end else begin
                s_d.idx = s_q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign held_o = s_q.held;
    assign idx_o  = s_q.idx;

endmodule

// File: rtl/wb_drain.sv
module wb_drain
    import pipe_sync_pkg::*;
#(
    parameter int SUBTILES = 4,
    parameter int EARLY_AT = 1,
    parameter bit EARLY_ON = 1'b1,
    localparam int SW = idx_width(SUBTILES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          held_i,
    input  logic          sub_done_i,
    output logic          free_o,   // accumulator may be marked empty
    output logic          done_o,   // draining finished
    output logic [SW-1:0] sub_o
);

    typedef struct packed {
        logic [SW-1:0] cnt;
    } drain_t;

    drain_t s_d, s_q;
    logic   pulse, last;

    assign pulse  = held_i && sub_done_i;
    assign last   = (s_q.cnt == SW'(SUBTILES - 1));
    assign done_o = pulse && last;

    generate
        if (EARLY_ON) begin : g_early
            assign free_o = pulse && (s_q.cnt == SW'(EARLY_AT));
        end else begin : g_late
            assign free_o = done_o;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (pulse) begin
            s_d.cnt = last ? '0 : s_q.cnt + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sub_o = s_q.cnt;

endmodule

// File: rtl/pipe_sync_ctrl.sv
module pipe_sync_ctrl
    import pipe_sync_pkg::*;
#(
    parameter int LOAD_SLOTS = 5,
    parameter int ACC_SLOTS  = 1,
    parameter int SUBTILES   = 4,
    parameter int EARLY_AT   = 1,
    parameter bit EARLY_EN   = 1'b1,
    localparam int LIW = idx_width(LOAD_SLOTS),
    localparam int AIW = idx_width(ACC_SLOTS),
    localparam int SW  = idx_width(SUBTILES),
    localparam int LCW = cnt_width(LOAD_SLOTS),
    localparam int ACW = cnt_width(ACC_SLOTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_acq_req,
    output logic           ld_acq_gnt,
    input  logic           ld_rel,
    output logic [LIW-1:0] ld_slot,
    input  logic           mc_acq_req,
    output logic           mc_acq_gnt,
    input  logic           mc_rel,
    output logic [LIW-1:0] mc_slot,
    input  logic           ma_acq_req,
    output logic           ma_acq_gnt,
    input  logic           ma_rel,
    output logic [AIW-1:0] ma_slot,
    input  logic           wb_acq_req,
    output logic           wb_acq_gnt,
    input  logic           wb_sub_done,
    output logic [AIW-1:0] wb_slot,
    output logic [SW-1:0]  wb_sub,
    output logic [LCW-1:0] ld_full_cnt,
    output logic [ACW-1:0] acc_full_cnt
);

    localparam bit EARLY_ACTIVE = EARLY_EN && (ACC_SLOTS == 1);

    logic [LOAD_SLOTS-1:0] st_fill, st_drain;
    logic [ACC_SLOTS-1:0]  ac_fill, ac_drain;
    logic ld_held, mc_held, ma_held, wb_held;
    logic ld_done, mc_done, ma_done;
    logic wb_free, wb_done;

    assign ld_done = ld_rel && ld_held;
    assign mc_done = mc_rel && mc_held;
    assign ma_done = ma_rel && ma_held;

    // Staging ring between loader and compute
    slot_ring #(.DEPTH(LOAD_SLOTS)) u_stage_ring (
        .clk, .rst_n,
        .fill_i(ld_done), .fill_idx_i(ld_slot),
        .drain_i(mc_done), .drain_idx_i(mc_slot),
        .fill_par_o(st_fill), .drain_par_o(st_drain),
        .full_cnt_o(ld_full_cnt)
    );

    ring_side #(.DEPTH(LOAD_SLOTS), .ROLE(ROLE_FILL)) u_loader (
        .clk, .rst_n,
        .acq_req_i(ld_acq_req), .fill_par_i(st_fill), .drain_par_i(st_drain),
        .adv_i(ld_done), .drop_i(ld_done),
        .acq_gnt_o(ld_acq_gnt), .held_o(ld_held), .idx_o(ld_slot)
    );

    ring_side #(.DEPTH(LOAD_SLOTS), .ROLE(ROLE_DRAIN)) u_cmp_rd (
        .clk, .rst_n,
        .acq_req_i(mc_acq_req), .fill_par_i(st_fill), .drain_par_i(st_drain),
        .adv_i(mc_done), .drop_i(mc_done),
        .acq_gnt_o(mc_acq_gnt), .held_o(mc_held), .idx_o(mc_slot)
    );

    // Accumulator ring between compute and writeback
    slot_ring #(.DEPTH(ACC_SLOTS)) u_acc_ring (
        .clk, .rst_n,
        .fill_i(ma_done), .fill_idx_i(ma_slot),
        .drain_i(wb_free), .drain_idx_i(wb_slot),
        .fill_par_o(ac_fill), .drain_par_o(ac_drain),
        .full_cnt_o(acc_full_cnt)
    );

    ring_side #(.DEPTH(ACC_SLOTS), .ROLE(ROLE_FILL)) u_cmp_acc (
        .clk, .rst_n,
        .acq_req_i(ma_acq_req), .fill_par_i(ac_fill), .drain_par_i(ac_drain),
        .adv_i(ma_done), .drop_i(ma_done),
        .acq_gnt_o(ma_acq_gnt), .held_o(ma_held), .idx_o(ma_slot)
    );

    // Writeback advances its index when the slot is freed, but stays
    // busy until the final sub-tile has been drained.
    ring_side #(.DEPTH(ACC_SLOTS), .ROLE(ROLE_DRAIN)) u_wback (
        .clk, .rst_n,
        .acq_req_i(wb_acq_req), .fill_par_i(ac_fill), .drain_par_i(ac_drain),
        .adv_i(wb_free), .drop_i(wb_done),
        .acq_gnt_o(wb_acq_gnt), .held_o(wb_held), .idx_o(wb_slot)
    );

    wb_drain #(
        .SUBTILES(SUBTILES), .EARLY_AT(EARLY_AT), .EARLY_ON(EARLY_ACTIVE)
    ) u_drain (
        .clk, .rst_n,
        .held_i(wb_held), .sub_done_i(wb_sub_done),
        .free_o(wb_free), .done_o(wb_done), .sub_o(wb_sub)
    );

endmodule

// File: rtl/pipe_sync_ctrl_chk.sv
module pipe_sync_ctrl_chk #(
    parameter int LOAD_SLOTS = 5,
    parameter int ACC_SLOTS  = 1,
    parameter int LCW = 3,
    parameter int ACW = 1,
    parameter int SW  = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ld_acq_gnt,
    input logic           ld_rel,
    input logic           mc_acq_gnt,
    input logic           mc_rel,
    input logic           ma_acq_gnt,
    input logic           wb_acq_gnt,
    input logic [SW-1:0]  wb_sub,
    input logic [LCW-1:0] ld_full_cnt,
    input logic [ACW-1:0] acc_full_cnt
);

    p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ld_full_cnt) <= LOAD_SLOTS && int'(acc_full_cnt) <= ACC_SLOTS);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ld_full_cnt) == LOAD_SLOTS |-> !ld_acq_gnt);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_full_cnt == '0 |-> !mc_acq_gnt);

    p_quiet_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_rel && !mc_rel) |=> $stable(ld_full_cnt));

    p_acc_full_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_full_cnt) == ACC_SLOTS |-> !ma_acq_gnt);

    p_acc_empty_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_full_cnt == '0 |-> !wb_acq_gnt);

    p_wb_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_acq_gnt |-> wb_sub == '0);

endmodule

bind pipe_sync_ctrl pipe_sync_ctrl_chk #(
    .LOAD_SLOTS(LOAD_SLOTS), .ACC_SLOTS(ACC_SLOTS),
    .LCW(LCW), .ACW(ACW), .SW(SW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ld_acq_gnt(ld_acq_gnt), .ld_rel(ld_rel),
    .mc_acq_gnt(mc_acq_gnt), .mc_rel(mc_rel),
    .ma_acq_gnt(ma_acq_gnt), .wb_acq_gnt(wb_acq_gnt),
    .wb_sub(wb_sub), .ld_full_cnt(ld_full_cnt), .acc_full_cnt(acc_full_cnt)
);

// File: tb/test_pipe_sync_ctrl.sv
`timescale 1ns/1ps
module test_pipe_sync_ctrl;

    localparam int LS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic ld_acq_req, ld_rel, mc_acq_req, mc_rel, ma_acq_req, ma_rel;
    logic wb_acq_req, wb_sub_done;
    logic ld_acq_gnt, mc_acq_gnt, ma_acq_gnt, wb_acq_gnt;
    logic [2:0] ld_slot, mc_slot;
    logic [0:0] ma_slot, wb_slot;
    logic [1:0] wb_sub;
    logic [2:0] ld_full_cnt;
    logic [0:0] acc_full_cnt;

    pipe_sync_ctrl i_pipe_sync_ctrl (
        .clk, .rst_n,
        .ld_acq_req, .ld_acq_gnt, .ld_rel, .ld_slot,
        .mc_acq_req, .mc_acq_gnt, .mc_rel, .mc_slot,
        .ma_acq_req, .ma_acq_gnt, .ma_rel, .ma_slot,
        .wb_acq_req, .wb_acq_gnt, .wb_sub_done, .wb_slot, .wb_sub,
        .ld_full_cnt, .acc_full_cnt
    );

    // Second instance: two accumulator slots, early freeing must stay off
    logic b_ma_acq_req, b_ma_rel, b_wb_acq_req, b_wb_sub_done;
    logic b_ma_acq_gnt, b_wb_acq_gnt, b_ld_gnt, b_mc_gnt;
    logic [2:0] b_ld_slot, b_mc_slot, b_ld_cnt;
    logic [0:0] b_ma_slot, b_wb_slot;
    logic [1:0] b_wb_sub, b_acc_full;

    pipe_sync_ctrl #(.ACC_SLOTS(2)) i_pipe_sync_ctrl_b (
        .clk, .rst_n,
        .ld_acq_req(1'b0), .ld_acq_gnt(b_ld_gnt), .ld_rel(1'b0), .ld_slot(b_ld_slot),
        .mc_acq_req(1'b0), .mc_acq_gnt(b_mc_gnt), .mc_rel(1'b0), .mc_slot(b_mc_slot),
        .ma_acq_req(b_ma_acq_req), .ma_acq_gnt(b_ma_acq_gnt), .ma_rel(b_ma_rel),
        .ma_slot(b_ma_slot),
        .wb_acq_req(b_wb_acq_req), .wb_acq_gnt(b_wb_acq_gnt),
        .wb_sub_done(b_wb_sub_done), .wb_slot(b_wb_slot), .wb_sub(b_wb_sub),
        .ld_full_cnt(b_ld_cnt), .acc_full_cnt(b_acc_full)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    int exp_q[$];
    int exp_ld = 0;

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic go();
        @(posedge clk);
        #1;
        ld_acq_req = 0; ld_rel = 0; mc_acq_req = 0; mc_rel = 0;
        ma_acq_req = 0; ma_rel = 0; wb_acq_req = 0; wb_sub_done = 0;
        b_ma_acq_req = 0; b_ma_rel = 0; b_wb_acq_req = 0; b_wb_sub_done = 0;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    task automatic load_one();
        go(); ld_acq_req = 1; smp();
        chk("R2 loader grant", ld_acq_gnt, 1);
        chk("R2 loader slot", ld_slot, exp_ld);
        go(); ld_rel = 1; smp();
        exp_q.push_back(exp_ld);
        exp_ld = (exp_ld + 1) % LS;
    endtask

    task automatic consume_one();
        go(); mc_acq_req = 1; smp();
        chk("R4 compute grant on full slot", mc_acq_gnt, 1);
        go(); mc_rel = 1; smp();
    endtask

    // Scoreboard monitor: compute grants must follow fill order (R5)
    always @(negedge clk) begin
        if (rst_n && mc_acq_gnt) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected compute grant", 1, 0);
            end else begin
                chk("R5 fill order", mc_slot, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        go();
        rst_n = 0;
        repeat (3) go();
        rst_n = 1;
        smp();
        // R1 reset state
        chk("R1 ld_full_cnt", ld_full_cnt, 0);
        chk("R1 acc_full_cnt", acc_full_cnt, 0);
        chk("R1 ld_slot", ld_slot, 0);
        chk("R1 mc_slot", mc_slot, 0);
        chk("R1 wb_sub", wb_sub, 0);
        go(); mc_acq_req = 1; smp();
        chk("R1 no compute grant after reset", mc_acq_gnt, 0);

        // R6 stray release ignored
        go(); ld_rel = 1; mc_rel = 1; smp();
        go(); smp();
        chk("R6 stray release count", ld_full_cnt, 0);
        chk("R6 stray release slot", ld_slot, 0);

        // R2 fill whole ring
        for (int i = 0; i < LS; i++) load_one();
        go(); smp();
        chk("R12 full count", ld_full_cnt, LS);
        chk("R2 loader wrapped", ld_slot, 0);

        // R3 ring full
        go(); ld_acq_req = 1; smp();
        chk("R3 no grant when full", ld_acq_gnt, 0);

        // R6 double acquire
        go(); mc_acq_req = 1; smp();
        chk("R4 compute grant", mc_acq_gnt, 1);
        go(); mc_acq_req = 1; smp();
        chk("R6 no grant while held", mc_acq_gnt, 0);

        // R7 collision: release slot 0 while loader asks for it
        go(); mc_rel = 1; ld_acq_req = 1; smp();
        chk("R7 same-cycle request refused", ld_acq_gnt, 0);
        go(); ld_acq_req = 1; smp();
        chk("R7 granted next cycle", ld_acq_gnt, 1);
        chk("R12 count after release", ld_full_cnt, LS - 1);
        chk("R7 loader slot", ld_slot, exp_ld);
        go(); ld_rel = 1; smp();
        exp_q.push_back(exp_ld);
        exp_ld = (exp_ld + 1) % LS;
        go(); smp();
        chk("R12 refilled", ld_full_cnt, LS);

        // R5 drain across the wrap (slot order checked by monitor)
        for (int i = 0; i < LS; i++) consume_one();
        go(); smp();
        chk("R4 ring empty", ld_full_cnt, 0);
        go(); mc_acq_req = 1; smp();
        chk("R4 no grant when empty", mc_acq_gnt, 0);
        chk("R5 scoreboard drained", exp_q.size(), 0);

        // R9 stray sub-tile pulse, R8 accumulator ring
        go(); wb_sub_done = 1; smp();
        go(); smp();
        chk("R9 stray sub pulse ignored", wb_sub, 0);
        go(); wb_acq_req = 1; smp();
        chk("R8 no writeback grant when empty", wb_acq_gnt, 0);
        go(); ma_acq_req = 1; smp();
        chk("R8 compute acc grant", ma_acq_gnt, 1);
        chk("R8 compute acc slot", ma_slot, 0);
        go(); ma_rel = 1; smp();
        go(); ma_acq_req = 1; smp();
        chk("R8 no compute acc grant when full", ma_acq_gnt, 0);
        chk("R12 acc count", acc_full_cnt, 1);
        go(); wb_acq_req = 1; smp();
        chk("R8 writeback grant", wb_acq_gnt, 1);

        // R10 early free after sub-tile 1
        go(); wb_sub_done = 1; smp();
        go(); smp();
        chk("R9 sub index", wb_sub, 1);
        chk("R10 still full before early point", acc_full_cnt, 1);
        go(); wb_sub_done = 1; smp();
        go(); ma_acq_req = 1; wb_acq_req = 1; smp();
        chk("R10 freed early", acc_full_cnt, 0);
        chk("R10 compute acc grant after early free", ma_acq_gnt, 1);
        chk("R10 writeback still busy", wb_acq_gnt, 0);
        chk("R9 sub index 2", wb_sub, 2);
        go(); ma_rel = 1; smp();
        go(); wb_sub_done = 1; smp();
        go(); wb_sub_done = 1; smp();
        go(); wb_acq_req = 1; smp();
        chk("R9 sub index wrapped", wb_sub, 0);
        chk("R10 refilled slot not freed again", acc_full_cnt, 1);
        chk("R9 writeback grant after drain", wb_acq_gnt, 1);

        // R11 two accumulator slots
        go(); b_ma_acq_req = 1; smp();
        chk("R11 acc grant slot0", b_ma_acq_gnt, 1);
        chk("R11 acc slot0", b_ma_slot, 0);
        go(); b_ma_rel = 1; smp();
        go(); b_ma_acq_req = 1; smp();
        chk("R11 acc grant slot1", b_ma_acq_gnt, 1);
        chk("R11 acc slot1", b_ma_slot, 1);
        go(); b_ma_rel = 1; smp();
        go(); b_wb_acq_req = 1; smp();
        chk("R11 writeback grant", b_wb_acq_gnt, 1);
        chk("R11 writeback slot0", b_wb_slot, 0);
        go(); b_wb_sub_done = 1; smp();
        go(); b_wb_sub_done = 1; smp();
        go(); smp();
        chk("R11 no early free", b_acc_full, 2);
        go(); b_wb_sub_done = 1; smp();
        go(); b_wb_sub_done = 1; smp();
        go(); smp();
        chk("R11 freed at last sub-tile", b_acc_full, 1);
        chk("R11 writeback next slot", b_wb_slot, 1);
        go(); b_ma_acq_req = 1; smp();
        chk("R11 compute reuses slot0", b_ma_acq_gnt, 1);
        chk("R11 compute slot wrapped", b_ma_slot, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule